// File: doc/BRIEF.md
# Reconfigurable Transposed-Form FIR Filter

This block is an N-tap FIR filter built in transposed direct form. Every tap multiplies the same input sample. No tap contains a general multiplier. One shared generator uses three adders to form the small odd multiples of the sample. Each tap then builds its coefficient product from up to five coded operands. Each operand picks one multiple, shifts it left by 0 to 15 places, and can be switched off on its own. An optional sign bit negates the sum of the operands.

Coefficients are held as two 18-bit coded words per tap, loaded through a simple write port. A new filter specification, or a shorter coefficient wordlength, needs only a reload of those words. A shorter wordlength uses fewer operand slots, and the disabled slots add nothing. Samples arrive with a valid strobe, and each accepted sample produces exactly one filtered output two cycles later. Samples may arrive with gaps, and the delay line does not move between them.

Top module: `fir_xpose_top`

## Requirements
- R1: For each accepted sample x, the output is p0 + z0. Each delay register zk becomes p(k+1) + z(k+1), and the last register takes p(N-1) alone. Here pk is tap k's coefficient times x.
- R2: out_valid is high exactly in the cycle two clock edges after an edge that accepted in_valid, and is low in every other cycle.
- R3: When in_valid is low, the delay registers and out_sample do not change, so gaps in the input stream leave the filter result unchanged.
- R4: Word 0 holds the sign in bit 17, operand slot 0 in bits 16:11, slot 1 in bits 10:5, and the enable mask in bits 4:0, where bit i enables slot i. Word 1 holds slot 2 in bits 17:12, slot 3 in bits 11:6 and slot 4 in bits 5:0. In each 6-bit slot, the upper four bits are a left shift and the lower two bits a multiple code: 01 = 1x, 10 = 3x, 11 = 5x, 00 = 7x. The coefficient is the sum of the enabled slots.
- R5: When the sign bit is set, the tap product is the negated sum of its operands.
- R6: A slot whose enable bit is clear contributes nothing, whatever its shift and code fields hold, so a short coefficient needs fewer slots.
- R7: A write stores cw_data into word cw_word of tap cw_tap. A write on the same edge that accepts a sample already applies to that sample. A write to an index of N or more is ignored.
- R8: After reset, out_valid is low, all delay registers are zero, and all coefficients are zero.
- R9: out_sample is bits FRAC+DW-1 down to FRAC of the exact sum. This drops the fractional bits toward minus infinity and keeps the low DW bits.
- R10: The accumulation is exact for N full-scale products, including all slots enabled at the 7x multiple with the maximum shift on every tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | DW | Signed input sample |
| cw_en | input | 1 | Coefficient word write strobe |
| cw_tap | input | clog2(N) | Tap index for the write |
| cw_word | input | 1 | Selects word 0 or word 1 of that tap |
| cw_data | input | 18 | Coded coefficient word |
| out_valid | output | 1 | Filtered sample strobe |
| out_sample | output | DW | Signed filtered sample |

## Verification
The bench first sends an impulse through coefficients whose slot shifts and codes differ from tap to tap. The impulse brings each coded coefficient out in tap order, so it separates errors in field decoding from errors in the delay chain. Further runs use negative coefficients, slots that carry data but are disabled, and runs with gaps in the valid strobe. These tell sign handling, mask handling and delay-line hold apart. Coefficient writes that land on the same cycle as samples, including writes to unused indices, test the write-to-use timing. Full-scale samples against full-scale coefficients expose any accumulator that is too narrow. A tap-0-only coefficient of one with a sample of -1 exposes rounding that goes the wrong way. A long random stream with random coefficient reloads then checks the whole recurrence against a reference model in the bench.

// File: rtl/fir_xpose_pkg.sv
package fir_xpose_pkg;

    localparam int CW_W  = 18;  // coded coefficient word width
    localparam int NSLOT = 5;   // operand slots per tap
    localparam int SHW   = 4;   // per-slot shift field width

    // multiple selected by an operand slot
    typedef enum logic [1:0] {
        SUB_X7 = 2'b00,
        SUB_X1 = 2'b01,
        SUB_X3 = 2'b10,
        SUB_X5 = 2'b11
    } sub_sel_e;

    typedef struct packed {
        logic [SHW-1:0] sh;
        sub_sel_e       sel;
    } slot_t;

    typedef struct packed {
        logic                  neg;
        logic [NSLOT-1:0]      en;
        slot_t [NSLOT-1:0]     slot;
    } coef_t;

    // map the two stored words of a tap onto decoded fields
    function automatic coef_t unpack_coef(input logic [CW_W-1:0] wa,
                                          input logic [CW_W-1:0] wb);
        coef_t c;
        c.neg     = wa[17];
        c.slot[0] = slot_t'(wa[16:11]);
        c.slot[1] = slot_t'(wa[10:5]);
        c.en      = wa[4:0];
        c.slot[2] = slot_t'(wb[17:12]);
        c.slot[3] = slot_t'(wb[11:6]);
        c.slot[4] = slot_t'(wb[5:0]);
        return c;
    endfunction

    // index into the table of multiples 0x..7x
    function automatic logic [2:0] sub_index(input sub_sel_e s);
        logic [2:0] idx;
        case (s)
            SUB_X1:  idx = 3'd1;
            SUB_X3:  idx = 3'd3;
            SUB_X5:  idx = 3'd5;
            default: idx = 3'd7;
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/fir_subexpr_gen.sv
// Shared generator of the eight multiples 0x..7x of one sample, three adders.
module fir_subexpr_gen #(
    parameter int DW = 16,
    parameter int XW = DW + 3
) (
    input  logic [DW-1:0]         x,
    output logic [7:0][XW-1:0]    mult
);
    logic signed [XW-1:0] xe;
    logic signed [XW-1:0] x3;
    logic signed [XW-1:0] x5;
    logic signed [XW-1:0] x7;

    always_comb begin
        xe = XW'(signed'(x));
        x3 = xe + (xe <<< 1);     // adder 1
        x5 = xe + (xe <<< 2);     // adder 2
        x7 = x3 + (xe <<< 2);     // adder 3
        mult[0] = '0;
        mult[1] = xe;
        mult[2] = xe <<< 1;
        mult[3] = x3;
        mult[4] = xe <<< 2;
        mult[5] = x5;
        mult[6] = x3 <<< 1;
        mult[7] = x7;
    end
endmodule

// File: rtl/fir_tap_mult.sv
// One tap: coded operand selection, per-slot shift, mask, sum and sign.
module fir_tap_mult
    import fir_xpose_pkg::*;
#(
    parameter int XW = 19,
    parameter int PW = 38
) (
    input  logic [7:0][XW-1:0]  mult,
    input  coef_t               coef,
    output logic [PW-1:0]       prod
);
    logic [NSLOT-1:0][PW-1:0] ops;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic signed [XW-1:0] pick;
        assign pick   = signed'(mult[sub_index(coef.slot[s].sel)]);
        assign ops[s] = coef.en[s] ? (PW'(pick) <<< coef.slot[s].sh) : '0;
    end

    logic signed [PW-1:0] sum;
    always_comb begin
        sum = '0;
        for (int s = 0; s < NSLOT; s++) begin
            sum = sum + signed'(ops[s]);
        end
        prod = coef.neg ? -sum : sum;
    end
endmodule

// File: rtl/fir_coef_bank.sv
// Coded coefficient storage, two words per tap, writable at any time.
module fir_coef_bank
    import fir_xpose_pkg::*;
#(
    parameter int NTAPS = 20,
    parameter int TIW   = $clog2(NTAPS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [TIW-1:0]          wr_tap,
    input  logic                    wr_word,
    input  logic [CW_W-1:0]         wr_data,
    output coef_t [NTAPS-1:0]       coefs
);
    typedef struct packed {
        logic [NTAPS-1:0][CW_W-1:0] wa;
        logic [NTAPS-1:0][CW_W-1:0] wb;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en && (32'(wr_tap) < NTAPS)) begin
            if (wr_word) begin
                bank_d.wb[wr_tap] = wr_data;
            end else begin
                bank_d.wa[wr_tap] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    for (genvar t = 0; t < NTAPS; t++) begin : g_dec
        assign coefs[t] = unpack_coef(bank_q.wa[t], bank_q.wb[t]);
    end
endmodule

// File: rtl/fir_xpose_top.sv
module fir_xpose_top
    import fir_xpose_pkg::*;
#(
    parameter int NTAPS = 20,
    parameter int DW    = 16,
    parameter int FRAC  = 15,
    localparam int TIW  = $clog2(NTAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_sample,
    input  logic             cw_en,
    input  logic [TIW-1:0]   cw_tap,
    input  logic             cw_word,
    input  logic [CW_W-1:0]  cw_data,
    output logic             out_valid,
    output logic [DW-1:0]    out_sample
);
    localparam int XW = DW + 3;
    localparam int PW = XW + (1 << SHW) - 1 + $clog2(NSLOT) + 1;
    localparam int AW = PW + $clog2(NTAPS);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] x;
    } stage_t;

    typedef struct packed {
        logic [NTAPS-2:0][AW-1:0] z;
        logic                     vld;
        logic [DW-1:0]            y;
    } chain_t;

    stage_t st_d, st_q;
    chain_t ch_d, ch_q;

    logic [7:0][XW-1:0]       mult;
    coef_t [NTAPS-1:0]        coefs;
    logic [NTAPS-1:0][PW-1:0] prod;
    logic signed [AW-1:0]     full;
    logic                     s1_vld;

    fir_coef_bank #(.NTAPS(NTAPS), .TIW(TIW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cw_en),
        .wr_tap  (cw_tap),
        .wr_word (cw_word),
        .wr_data (cw_data),
        .coefs   (coefs)
    );

    fir_subexpr_gen #(.DW(DW), .XW(XW)) u_gen (
        .x    (st_q.x),
        .mult (mult)
    );

    for (genvar t = 0; t < NTAPS; t++) begin : g_tap
        fir_tap_mult #(.XW(XW), .PW(PW)) u_mult (
            .mult (mult),
            .coef (coefs[t]),
            .prod (prod[t])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.x = in_sample;
        end

        ch_d     = ch_q;
        ch_d.vld = st_q.vld;
        full     = AW'(signed'(prod[0])) + signed'(ch_q.z[0]);
        if (st_q.vld) begin
            ch_d.y = full[FRAC +: DW];
            for (int k = 0; k < NTAPS - 2; k++) begin
                ch_d.z[k] = AW'(signed'(prod[k+1])) + ch_q.z[k+1];
            end
            ch_d.z[NTAPS-2] = AW'(signed'(prod[NTAPS-1]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            ch_q <= '0;
        end else begin
            st_q <= st_d;
            ch_q <= ch_d;
        end
    end

    assign s1_vld     = st_q.vld;
    assign out_valid  = ch_q.vld;
    assign out_sample = ch_q.y;
endmodule

// File: rtl/fir_xpose_chk.sv
module fir_xpose_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          s1_vld,
    input logic          out_valid,
    input logic [DW-1:0] out_sample
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1) |-> (s1_vld == $past(in_valid)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1 && !s1_vld) |=> (!out_valid && $stable(out_sample)));

    p_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd0) |-> !out_valid);

    p_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_sample));
endmodule

bind fir_xpose_top fir_xpose_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .s1_vld     (s1_vld),
    .out_valid  (out_valid),
    .out_sample (out_sample)
);

// File: tb/tb_fir_xpose_top.sv
module tb_fir_xpose_top;
    localparam int NT  = 20;
    localparam int DW  = 16;
    localparam int FR  = 15;
    localparam int TIW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_sample = '0;
    logic cw_en = 1'b0;
    logic [TIW-1:0] cw_tap = '0;
    logic cw_word = 1'b0;
    logic [17:0] cw_data = '0;
    logic out_valid;
    logic [DW-1:0] out_sample;

    always #4 clk = ~clk;

    fir_xpose_top #(.NTAPS(NT), .DW(DW), .FRAC(FR)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .cw_en(cw_en), .cw_tap(cw_tap), .cw_word(cw_word), .cw_data(cw_data),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    int n_chk = 0;
    int n_fail = 0;
    string tag = "R8";
    logic [17:0] mwa [NT];
    logic [17:0] mwb [NT];
    longint zm [NT-1];
    bit prev_v = 1'b0;
    logic [DW-1:0] prev_y = '0;

    function automatic longint mulof(input logic [1:0] s);
        case (s)
            2'b00:   return 7;
            2'b01:   return 1;
            2'b10:   return 3;
            default: return 5;
        endcase
    endfunction

    function automatic longint coefval(input logic [17:0] a, input logic [17:0] b);
        logic [5:0] f [5];
        longint v = 0;
        f[0] = a[16:11]; f[1] = a[10:5];
        f[2] = b[17:12]; f[3] = b[11:6]; f[4] = b[5:0];
        for (int s = 0; s < 5; s++) begin
            if (a[s]) v += mulof(f[s][1:0]) <<< f[s][5:2];
        end
        return a[17] ? -v : v;
    endfunction

    task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [DW-1:0] x, input bit w,
                        input int tap, input bit word, input logic [17:0] d);
        longint xs, acc;
        logic [DW-1:0] cy = '0;
        in_valid = v; in_sample = x;
        cw_en = w; cw_tap = tap[TIW-1:0]; cw_word = word; cw_data = d;
        if (w && tap < NT) begin
            if (word) mwb[tap] = d; else mwa[tap] = d;
        end
        if (v) begin
            xs  = longint'(signed'(x));
            acc = coefval(mwa[0], mwb[0]) * xs + zm[0];
            for (int k = 0; k < NT - 2; k++) zm[k] = coefval(mwa[k+1], mwb[k+1]) * xs + zm[k+1];
            zm[NT-2] = coefval(mwa[NT-1], mwb[NT-1]) * xs;
            cy = acc[FR+DW-1:FR];
        end
        @(posedge clk);
        @(negedge clk);
        check("R2", 32'(out_valid), 32'(prev_v));
        if (prev_v) check(tag, 32'(out_sample), 32'(prev_y));
        prev_v = v;
        prev_y = cy;
    endtask

    task automatic load(input int k, input logic [17:0] a, input logic [17:0] b);
        step(1'b0, '0, 1'b1, k, 1'b0, a);
        step(1'b0, '0, 1'b1, k, 1'b1, b);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 0, 1'b0, '0);
    endtask

    task automatic impulse(input logic [DW-1:0] x);
        step(1'b1, x, 1'b0, 0, 1'b0, '0);
        for (int i = 0; i < NT + 1; i++) step(1'b1, '0, 1'b0, 0, 1'b0, '0);
        idle(2);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NT; k++) begin mwa[k] = '0; mwb[k] = '0; end
        for (int k = 0; k < NT - 1; k++) zm[k] = 0;
        repeat (3) @(negedge clk);
        check("R8", 32'(out_valid), 32'd0);
        rst_n = 1'b1;

        // R8: coefficients are zero after reset
        tag = "R8";
        step(1'b1, 16'h1234, 1'b0, 0, 1'b0, '0);
        step(1'b1, 16'h7fff, 1'b0, 0, 1'b0, '0);
        idle(2);

        // R4: per-tap distinct slot fields, impulse reads them out in tap order
        tag = "R4";
        for (int k = 0; k < NT; k++)
            load(k, {1'b0, 4'(k % 16), 2'(k % 4), 4'((k + 3) % 16), 2'((k + 1) % 4),
                     ((k % 2) != 0) ? 5'b00011 : 5'b00001},
                    {4'(k % 7), 2'(k % 4), 6'h0, 6'h0});
        impulse(16'h2000);

        // R5: negative coefficients, positive and negative samples
        tag = "R5";
        for (int k = 0; k < NT; k += 3) load(k, {1'b1, 4'd5, 2'b10, 4'd2, 2'b00, 5'b10011},
                                              {4'd9, 2'b11, 4'd1, 2'b01, 4'd3, 2'b10});
        impulse(16'h0400);
        impulse(16'hf000);

        // R6: slot fields filled but mostly disabled
        tag = "R6";
        for (int k = 0; k < NT; k++)
            load(k, {1'b0, 4'd4, 2'b11, 4'd15, 2'b00, (k < 10) ? 5'b00001 : 5'b00000},
                    {4'd15, 2'b00, 4'd15, 2'b00, 4'd15, 2'b00});
        impulse(16'h7000);

        // R3: gaps in the input stream
        tag = "R3";
        for (int i = 0; i < 60; i++)
            step(1'($urandom_range(0, 1)), 16'($urandom), 1'b0, 0, 1'b0, '0);
        idle(2);

        // R7: writes on the same edge as samples, including unused indices
        tag = "R7";
        for (int i = 0; i < 60; i++)
            step(1'b1, 16'($urandom), 1'b1, $urandom_range(0, 31), 1'($urandom_range(0, 1)),
                 18'($urandom));
        idle(2);

        // R9: coefficient of one on tap 0 only, fraction dropped toward minus infinity
        tag = "R9";
        for (int k = 0; k < NT; k++) load(k, (k == 0) ? 18'b0_0000_01_0000_00_00001 : 18'd0, 18'd0);
        step(1'b1, 16'hffff, 1'b0, 0, 1'b0, '0);
        step(1'b1, 16'h0001, 1'b0, 0, 1'b0, '0);
        step(1'b1, 16'h8000, 1'b0, 0, 1'b0, '0);
        idle(2);

        // R10: full-scale coefficients on every tap with full-scale samples
        tag = "R10";
        for (int k = 0; k < NT; k++)
            load(k, {1'b0, 4'hf, 2'b00, 4'hf, 2'b00, 5'b11111}, {4'hf, 2'b00, 4'hf, 2'b00, 4'hf, 2'b00});
        for (int i = 0; i < NT + 4; i++) step(1'b1, 16'h8000, 1'b0, 0, 1'b0, '0);
        for (int i = 0; i < NT + 4; i++) step(1'b1, (i % 2) ? 16'h8000 : 16'h7fff, 1'b0, 0, 1'b0, '0);
        idle(2);

        // R1: random stream with random reloads
        tag = "R1";
        for (int i = 0; i < 400; i++)
            step(($urandom_range(0, 9) < 7), 16'($urandom), ($urandom_range(0, 4) == 0),
                 $urandom_range(0, NT - 1), 1'($urandom_range(0, 1)), 18'($urandom));
        idle(3);

        finish_run();
    end
endmodule